// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. It steps through a fixed set of states on each clock and drives every datapath control line: memory enables, instruction-register capture, register-file write, the multiplexer selects, the ALU operation class and the program-counter write enables. Every output is a function of the current state alone, so the lines are stable for the whole cycle and never glitch with the opcode.

Each instruction begins with a shared fetch cycle and a shared decode cycle. The opcode is consulted when leaving decode, and for memory instructions once more when leaving address computation. A branch then needs one more cycle, a jump one more, an ALU register instruction or a store two more, and a load three more. The sequencer then returns to fetch. The datapath must hold the opcode in its instruction register from the end of fetch until the instruction is complete. An assertion of the synchronous reset always puts the sequencer back in fetch.

Top module: `mc_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, the outputs in the following cycle carry the fetch vector given in R2, whatever the sequencer was doing before.
- R2: The fetch cycle drives `mem_rd`=1, `addr_sel`=0 (PC is the address), `ir_wr`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add), `pc_src`=00 (ALU result), and `pc_wr`=1. Every other output is 0.
- R3: The cycle after fetch is decode, for any opcode. It drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted sign-extended offset), and `alu_op`=00. All write and memory enables are 0 and every other output is 0.
- R4: A load (opcode 35) goes through three cycles after decode. The first is address computation: `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended offset), `alu_op`=00. The second is a memory read: `mem_rd`=1, `addr_sel`=1. The third is write-back: `reg_wr`=1, `wb_sel`=1 (memory data), `dst_sel`=0. The sequencer then returns to fetch, for 5 cycles in total.
- R5: A store (opcode 43) goes through address computation and then a memory write with `mem_wr`=1 and `addr_sel`=1. It then returns to fetch, for 4 cycles in total.
- R6: An ALU register instruction (opcode 0) first drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_op`=10 (use function field). It then completes with `reg_wr`=1, `dst_sel`=1, `wb_sel`=0. It then returns to fetch, for 4 cycles in total.
- R7: A branch (opcode 4) takes one cycle after decode. That cycle drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_src`=01 (saved target) and `pc_wr_cond`=1, with `pc_wr`=0. The sequencer then returns to fetch, for 3 cycles in total. `pc_wr_cond` is 1 in no other cycle.
- R8: A jump (opcode 2) takes one cycle after decode. That cycle drives `pc_src`=10 (jump target) and `pc_wr`=1, with every other output 0. The sequencer then returns to fetch, for 3 cycles in total.
- R9: Any other opcode returns to fetch directly after decode. Nothing is written.
- R10: A change of `opcode` within an execute or completion cycle leaves that cycle's outputs unchanged. Once memory address computation is over, the change also leaves the rest of the sequence unchanged.
- R11: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch, active high |
| opcode | input | OPW | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr | output | 1 | Instruction register write |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 offset, 11 offset shifted by 2 |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump target |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |

## Verification
The bench builds the sequencer with its default opcode width of 6 and the default opcode values. With these, all ten states and every exit from decode and from address computation can be reached from real instruction codes. Codes outside the five known ones, such as 63 and 8, exercise the fallback exit from decode. A reset issued in the middle of a load, and an opcode that changes during the ALU execute cycle, cover the resynchronisation path and the rule that outputs depend on the state alone.

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_ALU = 0,
  parameter logic [OPW-1:0] OP_LD  = 35,
  parameter logic [OPW-1:0] OP_ST  = 43,
  parameter logic [OPW-1:0] OP_BR  = 4,
  parameter logic [OPW-1:0] OP_JMP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           addr_sel,
  output logic           ir_wr,
  output logic           reg_wr,
  output logic           dst_sel,
  output logic           wb_sel,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic [1:0]     pc_src,
  output logic           pc_wr,
  output logic           pc_wr_cond
);

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_MRD, S_LWB, S_MWR, S_REXE, S_RDONE, S_BR, S_JMP
  } st_t;

  st_t st, st_nx;

  always_ff @(posedge clk)
    if (rst) st <= S_FETCH;
    else     st <= st_nx;

  always_comb begin
    st_nx = S_FETCH;
    case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE:
        if (opcode == OP_LD || opcode == OP_ST) st_nx = S_ADDR;
        else if (opcode == OP_ALU)              st_nx = S_REXE;
        else if (opcode == OP_BR)               st_nx = S_BR;
        else if (opcode == OP_JMP)              st_nx = S_JMP;
        else                                    st_nx = S_FETCH;
      S_ADDR:   st_nx = (opcode == OP_LD) ? S_MRD : S_MWR;
      S_MRD:    st_nx = S_LWB;
      S_REXE:   st_nx = S_RDONE;
      default:  st_nx = S_FETCH;
    endcase
  end

  always_comb begin
    {mem_rd, mem_wr, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, alu_a_sel} = '0;
    alu_b_sel  = 2'b00;
    alu_op     = 2'b00;
    pc_src     = 2'b00;
    pc_wr      = 1'b0;
    pc_wr_cond = 1'b0;
    case (st)
      S_FETCH: begin
        mem_rd = 1'b1; ir_wr = 1'b1; alu_b_sel = 2'b01; pc_wr = 1'b1;
      end
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR:   begin alu_a_sel = 1'b1; alu_b_sel = 2'b10; end
      S_MRD:    begin mem_rd = 1'b1; addr_sel = 1'b1; end
      S_LWB:    begin reg_wr = 1'b1; wb_sel = 1'b1; end
      S_MWR:    begin mem_wr = 1'b1; addr_sel = 1'b1; end
      S_REXE:   begin alu_a_sel = 1'b1; alu_op = 2'b10; end
      S_RDONE:  begin reg_wr = 1'b1; dst_sel = 1'b1; end
      S_BR: begin
        alu_a_sel = 1'b1; alu_op = 2'b01; pc_src = 2'b01; pc_wr_cond = 1'b1;
      end
      S_JMP:    begin pc_src = 2'b10; pc_wr = 1'b1; end
      default: ;
    endcase
  end

  assert_reset_to_fetch_R1: assert property (@(posedge clk)
    rst |=> (ir_wr && mem_rd && pc_wr && !reg_wr && !mem_wr));

  assert_decode_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!mem_rd && !mem_wr && !reg_wr && !pc_wr && !pc_wr_cond && alu_b_sel == 2'b11));

  assert_load_writeback_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_wr && wb_sel && !dst_sel));

  assert_branch_shape_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (alu_op == 2'b01 && !pc_wr && pc_src == 2'b01));

  assert_branch_returns_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr);

  assert_jump_returns_R8: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b10) |=> ir_wr);

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sim_mc_sequencer.sv
module sim_mc_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic       mem_rd, mem_wr, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic       pc_wr, pc_wr_cond;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sequencer u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .reg_wr(reg_wr), .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond)
  );

  wire [15:0] act = {mem_rd, mem_wr, addr_sel, ir_wr, reg_wr, dst_sel, wb_sel,
                     alu_a_sel, alu_b_sel, alu_op, pc_src, pc_wr, pc_wr_cond};

  function automatic logic [15:0] mk(logic rd, logic wr, logic as, logic ir,
      logic rw, logic ds, logic ws, logic aa, logic [1:0] ab, logic [1:0] ao,
      logic [1:0] ps, logic pw, logic pc);
    return {rd, wr, as, ir, rw, ds, ws, aa, ab, ao, ps, pw, pc};
  endfunction

  localparam logic [15:0] V_FETCH = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b1,1'b0};
  logic [15:0] v_dec, v_addr, v_mrd, v_lwb, v_mwr, v_rexe, v_rdone, v_br, v_jmp;

  initial begin
    v_dec   = mk(0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0,0);
    v_addr  = mk(0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0);
    v_mrd   = mk(1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0);
    v_lwb   = mk(0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00,0,0);
    v_mwr   = mk(0,1,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0);
    v_rexe  = mk(0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0,0);
    v_rdone = mk(0,0,0,0,1,1,0,0,2'b00,2'b00,2'b00,0,0);
    v_br    = mk(0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,0,1);
    v_jmp   = mk(0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,1,0);
  end

  task automatic push(logic [15:0] v, string tag);
    item_t it;
    it.v = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(logic [15:0] a, logic [15:0] e, string tag);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, a, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(act, it.v, it.tag);
      end
    end
  end

  task automatic run(logic [5:0] op, string what);
    opcode = op;
    push(V_FETCH, {"R2 fetch ", what});
    push(v_dec,   {"R3 decode ", what});
    case (op)
      6'd35: begin
        push(v_addr, "R4 load addr"); push(v_mrd, "R4 load read");
        push(v_lwb, "R4 load writeback"); step(5);
      end
      6'd43: begin
        push(v_addr, "R5 store addr"); push(v_mwr, "R5 store write"); step(4);
      end
      6'd0: begin
        push(v_rexe, "R6 alu execute"); push(v_rdone, "R6 alu complete"); step(4);
      end
      6'd4: begin push(v_br, "R7 branch"); step(3); end
      6'd2: begin push(v_jmp, "R8 jump"); step(3); end
      default: step(2);
    endcase
  endtask

  initial begin : driver
    step(2);
    check(act, V_FETCH, "R1 reset state");
    rst = 1'b0;
    run(6'd35, "load");
    run(6'd43, "store");
    run(6'd0,  "alu");
    run(6'd4,  "branch");
    run(6'd2,  "jump");
    run(6'd63, "R9 unknown 63");
    run(6'd8,  "R9 unknown 8");
    run(6'd4,  "R9 branch after unknown");
    // R10: opcode changes during the ALU execute cycle
    opcode = 6'd0;
    push(V_FETCH, "R10 fetch"); push(v_dec, "R10 decode");
    push(v_rexe, "R10 execute held"); push(v_rdone, "R10 complete held");
    step(2);
    opcode = 6'd63;
    step(2);
    // R1: reset in the middle of a load
    opcode = 6'd35;
    push(V_FETCH, "R1 pre-reset fetch"); push(v_dec, "R1 pre-reset decode");
    step(2);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    run(6'd35, "R1 load after reset");
    run(6'd43, "store again");
    step(1);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual=%0d leftover expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule